// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from a single asynchronous serial line. Each character is framed by a low start bit and a high stop bit. Between them come 8 or 9 data bits, least significant bit first. The line is oversampled by a per-sample tick from an external baud-rate generator, at 16 ticks per bit. It passes through a two-flop synchronizer before any decision is taken. Completed characters move in parallel from the shift register into a two-entry first-in first-out buffer. The host sees the oldest entry, its framing flag, a ready flag and an overrun flag.

The host drives plain strobes instead of a register bus: a read strobe pops the oldest character, a continuous-receive enable starts or stops reception and clears a sticky overrun, and a port enable resets everything when low. In 9-bit mode an address-filter input lets only characters whose ninth bit is 1 into the buffer. An idle output shows when no character is being assembled.

Top module: `async_rx_top`

## Requirements
- R1: In 8-bit mode (`nineBit`=0) a character is a 0 start bit, 8 data bits LSB first and a stop bit. Its value appears on `rxData[7:0]` with `rxData[8]`=0.
- R2: In 9-bit mode (`nineBit`=1) nine data bits are received LSB first, and the last one received appears on `rxData[8]`.
- R3: The buffer holds up to two characters and returns them in arrival order. `rxReady` is 1 while at least one is held. Each `readStrobe` pulse removes the oldest one, and `rxReady` returns to 0 once the buffer is read empty.
- R4: A character that completes while both entries are full is discarded and sets `overrunErr`. While `overrunErr` is 1 no new start bit is accepted. Driving `rxEn` low clears `overrunErr`.
- R5: A character whose stop bit samples as 0 is still stored, and `rxReady` still rises. `frameErr` is 1 while that character is the oldest entry, and the flag leaves with it when it is read.
- R6: With `addrDet`=1, only 9-bit characters whose ninth bit is 1 are stored. All other characters, including every 8-bit character, leave the buffer unchanged.
- R7: `rxIdle` is 1 when no character is in progress. It is 0 from start-bit detection until the stop bit has been sampled.
- R8: While `portEn` is 0 the buffer is emptied and all flags are cleared.
- R9: A start bit is accepted only if the line is still low at the middle of the start bit. A shorter low pulse stores nothing and leaves the receiver idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Serial-port enable; low resets receiver, buffer and flags |
| rxEn | input | 1 | Continuous-receive enable; low aborts reception and clears overrun |
| nineBit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addrDet | input | 1 | 1 stores only 9-bit characters with ninth bit set |
| sampleTick | input | 1 | Oversampling tick, 16 per bit time |
| rxLine | input | 1 | Asynchronous serial input, idles high |
| readStrobe | input | 1 | One-cycle pulse that pops the oldest character |
| rxData | output | 9 | Oldest buffered character |
| rxReady | output | 1 | Buffer holds at least one character |
| frameErr | output | 1 | Oldest character had a low stop bit |
| overrunErr | output | 1 | Sticky overrun flag |
| rxIdle | output | 1 | No character in progress |

## Verification
With the tick held high, the line reaches the state machine two clocks after it changes. The start bit is accepted nine clocks after its falling edge. The stop bit is sampled eight to nine clocks into it, and the character is in the buffer two clocks later, before the stop bit ends. The bench therefore checks `rxReady`, `rxData` and `frameErr` only after the full stop bit and some idle time. It checks `rxIdle` at the middle of the second data bit. A read or a change of `rxEn` or `portEn` takes effect at the next clock edge, so those results are sampled at the falling edge one cycle later.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxStateT;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic charDone;
    logic stopBad;
  } rxStrobeT;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int MAXBITS = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     portEn,
  input  logic     rxEn,
  input  logic     blockRx,
  input  logic     nineBit,
  input  logic     tick,
  input  logic     lineIn,
  output rxStrobeT strobe,
  output logic     idle
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(MAXBITS);
  localparam int MID = OVS / 2 - 1;

  logic [1:0]    syncQ;
  logic          lineS;
  rxStateT       state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;
  logic [BW-1:0] lastIdx;

  assign lineS   = syncQ[1];
  assign lastIdx = nineBit ? BW'(MAXBITS - 1) : BW'(MAXBITS - 2);
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      strobe <= '0;
    end else if (!portEn || !rxEn) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      strobe <= '0;
    end else begin
      strobe <= '0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!lineS && !blockRx) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == CW'(MID)) begin
              cnt    <= '0;
              bitIdx <= '0;
              state  <= lineS ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(OVS - 1)) begin
              strobe.shiftEn  <= 1'b1;
              strobe.shiftBit <= lineS;
              if (bitIdx == lastIdx) state <= ST_STOP;
              else                   bitIdx <= bitIdx + 1'b1;
            end
          end
          ST_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(OVS - 1)) begin
              strobe.charDone <= 1'b1;
              strobe.stopBad  <= !lineS;
              state           <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  shift_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftEn && strobe.charDone));

  // R9
  no_start_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !tick) |=> idle);

  // R4
  blocked_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && blockRx) |=> idle);
endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import rx_pkg::*;
#(
  parameter int MAXBITS = 9,
  parameter int DEPTH   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portEn,
  input  logic               rxEn,
  input  logic               nineBit,
  input  logic               addrDet,
  input  rxStrobeT           strobe,
  input  logic               readStrobe,
  output logic [MAXBITS-1:0] rxData,
  output logic               rxReady,
  output logic               frameErr,
  output logic               overrunErr
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int EW   = MAXBITS + 1;

  logic [MAXBITS-1:0] shiftReg;
  logic [MAXBITS-1:0] word;
  logic [EW-1:0]      mem [DEPTH];
  logic [PW-1:0]      wrPtr, rdPtr;
  logic [CNTW-1:0]    count;
  logic               accept, full, push, pop, ovfSet;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign word   = nineBit ? shiftReg : {1'b0, shiftReg[MAXBITS-1:1]};
  assign accept = strobe.charDone && (!addrDet || (nineBit && word[MAXBITS-1]));
  assign pop    = readStrobe && (count != '0);
  assign full   = (count == CNTW'(DEPTH)) && !pop;
  assign push   = accept && !overrunErr && !full;
  assign ovfSet = accept && !overrunErr && full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (!portEn)         shiftReg <= '0;
    else if (strobe.shiftEn)  shiftReg <= {strobe.shiftBit, shiftReg[MAXBITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      overrunErr <= 1'b0;
    end else if (!portEn) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      overrunErr <= 1'b0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (!rxEn)       overrunErr <= 1'b0;
      else if (ovfSet) overrunErr <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       mem[i] <= '0;
      else if (push && wrPtr == PW'(i)) mem[i] <= {strobe.stopBad, word};
    end
  end

  assign rxReady  = (count != '0);
  assign rxData   = mem[rdPtr][MAXBITS-1:0];
  assign frameErr = rxReady && mem[rdPtr][MAXBITS];

  // R3
  ready_falls_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> ($past(readStrobe) || !$past(portEn)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));

  // R4
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && rxEn && portEn) |=> overrunErr);

  // R8
  port_off_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!rxReady && !overrunErr && !frameErr));
endmodule

// File: rtl/async_rx_top.sv
module async_rx_top
  import rx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int MAXBITS = 9,
  parameter int DEPTH   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portEn,
  input  logic               rxEn,
  input  logic               nineBit,
  input  logic               addrDet,
  input  logic               sampleTick,
  input  logic               rxLine,
  input  logic               readStrobe,
  output logic [MAXBITS-1:0] rxData,
  output logic               rxReady,
  output logic               frameErr,
  output logic               overrunErr,
  output logic               rxIdle
);
  rxStrobeT strobe;

  rx_ctrl #(.OVS(OVS), .MAXBITS(MAXBITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .rxEn(rxEn),
    .blockRx(overrunErr), .nineBit(nineBit), .tick(sampleTick),
    .lineIn(rxLine), .strobe(strobe), .idle(rxIdle)
  );

  rx_dpath #(.MAXBITS(MAXBITS), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .portEn(portEn), .rxEn(rxEn),
    .nineBit(nineBit), .addrDet(addrDet), .strobe(strobe),
    .readStrobe(readStrobe), .rxData(rxData), .rxReady(rxReady),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );
endmodule

// File: tb/sim_async_rx_top.sv
module sim_async_rx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEn = 1'b1, rxEn = 1'b1, nineBit = 1'b0, addrDet = 1'b0;
  logic sampleTick = 1'b1, rxLine = 1'b1, readStrobe = 1'b0;
  logic [8:0] rxData;
  logic rxReady, frameErr, overrunErr, rxIdle;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  async_rx_top u0 (
    .clk(clk), .rstN(rstN), .portEn(portEn), .rxEn(rxEn), .nineBit(nineBit),
    .addrDet(addrDet), .sampleTick(sampleTick), .rxLine(rxLine),
    .readStrobe(readStrobe), .rxData(rxData), .rxReady(rxReady),
    .frameErr(frameErr), .overrunErr(overrunErr), .rxIdle(rxIdle)
  );

  // fields: [12] nine, [11] addrDet, [10] stop level, [9:1] data, [0] stored
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 9'h0A5, 1'b1},  // R1
    {1'b0, 1'b0, 1'b1, 9'h03C, 1'b1},  // R1
    {1'b1, 1'b0, 1'b1, 9'h1C3, 1'b1},  // R2
    {1'b1, 1'b0, 1'b1, 9'h055, 1'b1},  // R2
    {1'b1, 1'b1, 1'b1, 9'h17E, 1'b1},  // R6 address char kept
    {1'b1, 1'b1, 1'b1, 9'h07E, 1'b0},  // R6 data char dropped
    {1'b0, 1'b1, 1'b1, 9'h0FF, 1'b0},  // R6 8-bit dropped
    {1'b0, 1'b0, 1'b0, 9'h081, 1'b1}   // R5 low stop bit
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic stopV, input logic busy);
    @(negedge clk);
    holdBit(1'b0);
    for (int i = 0; i < (nineBit ? 9 : 8); i++) begin
      rxLine = d[i];
      repeat (8) @(negedge clk);
      if (i == 1) check("R7 idle mid-frame", int'(rxIdle), int'(!busy));
      repeat (8) @(negedge clk);
    end
    holdBit(stopV);
    rxLine = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic readOne();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset ready", int'(rxReady), 0);
    check("R8 reset overrun", int'(overrunErr), 0);
    check("R8 reset frameErr", int'(frameErr), 0);
    check("R7 reset idle", int'(rxIdle), 1);

    for (int v = 0; v < 8; v++) begin
      logic [8:0] exp;
      nineBit = VEC[v][12];
      addrDet = VEC[v][11];
      exp = VEC[v][12] ? VEC[v][9:1] : {1'b0, VEC[v][8:1]};
      sendFrame(VEC[v][9:1], VEC[v][10], 1'b1);
      check("R1/R2/R6 stored", int'(rxReady), int'(VEC[v][0]));
      if (VEC[v][0]) begin
        check("R1/R2 data", int'(rxData), int'(exp));
        check("R5 frame flag", int'(frameErr), int'(!VEC[v][10]));
        readOne();
        check("R3 empty after read", int'(rxReady), 0);
        check("R5 flag cleared on read", int'(frameErr), 0);
      end
    end
    nineBit = 1'b0;
    addrDet = 1'b0;

    // R3 two entries in order
    sendFrame(9'h011, 1'b1, 1'b1);
    sendFrame(9'h022, 1'b1, 1'b1);
    check("R3 first", int'(rxData), 'h11);
    readOne();
    check("R3 second", int'(rxData), 'h22);
    check("R3 still ready", int'(rxReady), 1);
    readOne();
    check("R3 drained", int'(rxReady), 0);

    // R4 overrun and recovery
    sendFrame(9'h0A1, 1'b1, 1'b1);
    sendFrame(9'h0A2, 1'b1, 1'b1);
    check("R4 no overrun at two", int'(overrunErr), 0);
    sendFrame(9'h0A3, 1'b1, 1'b1);
    check("R4 overrun set", int'(overrunErr), 1);
    sendFrame(9'h0A4, 1'b1, 1'b0);
    check("R4 head kept", int'(rxData), 'hA1);
    readOne();
    check("R4 second kept", int'(rxData), 'hA2);
    readOne();
    check("R4 extra chars dropped", int'(rxReady), 0);
    check("R4 overrun still set", int'(overrunErr), 1);
    rxEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 overrun cleared", int'(overrunErr), 0);
    rxEn = 1'b1;
    sendFrame(9'h05A, 1'b1, 1'b1);
    check("R4 receives again", int'(rxData), 'h5A);
    readOne();

    // R9 short low pulse
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    check("R9 glitch not stored", int'(rxReady), 0);
    check("R9 back to idle", int'(rxIdle), 1);

    // R8 port disable clears buffer and overrun
    sendFrame(9'h0B1, 1'b1, 1'b1);
    sendFrame(9'h0B2, 1'b1, 1'b1);
    sendFrame(9'h0B3, 1'b1, 1'b1);
    check("R8 setup overrun", int'(overrunErr), 1);
    portEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 buffer cleared", int'(rxReady), 0);
    check("R8 overrun cleared", int'(overrunErr), 0);
    portEn = 1'b1;
    sendFrame(9'h0C4, 1'b0, 1'b1);
    portEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 frame flag cleared", int'(frameErr), 0);
    portEn = 1'b1;

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule